// File: doc/BRIEF.md
# Lane-Paired Hamming-Protected Word Store

This block is the data path of a small memory. Each stored word is built from two write beats on one 9-bit lane. Each lane holds one 18-bit word per address. A 23-bit single-error-correcting Hamming code protects that word, and its five check bits are never visible at the ports. Writes supply both beats together, each with its own active-low per-lane byte mask. On every read the stored code word is decoded, and one flipped bit is repaired before the two beats come out.

If a lane is written for only one of its two beats, the five check bits can no longer describe the whole word. The first such half write therefore sets a sticky flag that turns correction off until reset. From then on, reads return the stored bits as they are. A test port flips any single code-word bit at any address and lane, so the corrector can be exercised.

Top module: `ecc_word_store`

## Requirements
- R1: After reset, `rd_valid`, `rd_fix` and `ecc_off` are 0, and reset clears `ecc_off` again after it has been set.
- R2: A full write followed by a read of the same address returns both beats unchanged. Lane l occupies bits [9l+8:9l] of the beat-1 bus `wr_d0`/`rd_q0` and of the beat-2 bus `wr_d1`/`rd_q1`. Read results appear one clock after `rd_en` is sampled.
- R3: While `ecc_off` is 0, a single flipped bit at any data position of a lane's code word is corrected on read, and `rd_fix` is 1. Code-word positions run 1..23, with check bits at positions 1, 2, 4, 8 and 16. Data bits 0..17 fill the remaining positions in ascending order. Data bits 0..8 are the beat-1 byte and bits 9..17 the beat-2 byte.
- R4: While `ecc_off` is 0, a single flipped check bit leaves the read data unchanged and sets `rd_fix` to 1.
- R5: Per lane, active-low masks `mask0_n` (beat 1) and `mask1_n` (beat 2) both low give a full write. Both high abort the write, and the lane keeps its previous contents.
- R6: A half write (one mask low and the other high on a lane) stores only the selected 9-bit byte and keeps the other. It sets `ecc_off` one clock later, and `ecc_off` then stays 1 until reset.
- R7: While `ecc_off` is 1, reads return the raw stored data with no correction, and `rd_fix` stays 0.
- R8: A full write regenerates all check bits, so a word that held an injected error reads back clean (`rd_fix` 0) after being fully rewritten.
- R9: A read and a write to the same address in the same clock return the contents from before the write.
- R10: Mask bit l governs lane l only, so other lanes of the same write are unaffected by it.
- R11: `rd_valid` is 1 exactly in the clock after a sampled `rd_en`. Without a read, `rd_q0`/`rd_q1` hold their values and `rd_valid` and `rd_fix` are 0.
- R12: `inj_en` flips code-word position `inj_pos` (1..23) of lane `inj_lane` at `inj_addr`. Position 0 or a value above 23 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_d0 | input | 9*LANES | Beat-1 write data |
| wr_d1 | input | 9*LANES | Beat-2 write data |
| mask0_n | input | LANES | Beat-1 byte masks, active low |
| mask1_n | input | LANES | Beat-2 byte masks, active low |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| inj_en | input | 1 | Test: flip one stored code-word bit |
| inj_addr | input | AW | Test: address to corrupt |
| inj_lane | input | LW | Test: lane to corrupt |
| inj_pos | input | 5 | Test: code-word position 1..23 |
| rd_q0 | output | 9*LANES | Beat-1 read data |
| rd_q1 | output | 9*LANES | Beat-2 read data |
| rd_valid | output | 1 | Read data valid |
| rd_fix | output | 1 | A nonzero in-range syndrome was repaired on this read |
| ecc_off | output | 1 | Sticky: correction disabled after a half write |

## Verification
The bound checker checks on every cycle that the disable flag never drops without reset and rises after any half write. It also checks that valid follows a read by one clock, that outputs hold while idle, and that the repair flag never appears with correction off or without valid data. Only the bench's scenarios can show the data itself. These cover correction of each of the 23 positions on each lane, check-bit hits leaving data intact, mask merging and aborts per lane, read-before-write ordering, and raw data once correction has been switched off.

// File: rtl/ecc_word_store.sv
module ecc_word_store #(
  parameter int LANES = 2,
  parameter int AW    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [9*LANES-1:0]   wr_d0,
  input  logic [9*LANES-1:0]   wr_d1,
  input  logic [LANES-1:0]     mask0_n,
  input  logic [LANES-1:0]     mask1_n,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  input  logic                 inj_en,
  input  logic [AW-1:0]        inj_addr,
  input  logic [(LANES>1 ? $clog2(LANES) : 1)-1:0] inj_lane,
  input  logic [4:0]           inj_pos,
  output logic [9*LANES-1:0]   rd_q0,
  output logic [9*LANES-1:0]   rd_q1,
  output logic                 rd_valid,
  output logic                 rd_fix,
  output logic                 ecc_off
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = 23;

  function automatic logic [CW-1:0] put_data(input logic [CW-1:0] cw, input logic [17:0] d);
    int k;
    k = 0;
    put_data = cw;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        put_data[p-1] = d[k];
        k++;
      end
  endfunction

  function automatic logic [17:0] get_data(input logic [CW-1:0] cw);
    int k;
    k = 0;
    get_data = '0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        get_data[k] = cw[p-1];
        k++;
      end
  endfunction

  function automatic logic [4:0] syndrome(input logic [CW-1:0] cw);
    syndrome = '0;
    for (int p = 1; p <= CW; p++)
      if (cw[p-1]) syndrome = syndrome ^ 5'(p);
  endfunction

  function automatic logic [CW-1:0] encode(input logic [17:0] d);
    logic [4:0] s;
    encode = put_data('0, d);
    s = syndrome(encode);
    for (int j = 0; j < 5; j++) encode[(1 << j) - 1] = s[j];
  endfunction

  logic [CW-1:0] mem [DEPTH][LANES];
  logic [CW-1:0] new_word [LANES];
  logic [17:0]   rd_dat [LANES];
  logic [LANES-1:0] lane_touch, lane_hit;
  logic [CW-1:0] inj_mask;
  logic [CW-1:0] inj_base;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CW-1:0] old_w, rd_w, fixed_w;
    logic [17:0]   old_d, mrg;
    logic [4:0]    s;
    logic          full;

    assign old_w = mem[wr_addr][l];
    assign old_d = get_data(old_w);
    assign mrg   = {mask1_n[l] ? old_d[17:9] : wr_d1[9*l +: 9],
                    mask0_n[l] ? old_d[8:0]  : wr_d0[9*l +: 9]};
    assign full  = !mask0_n[l] && !mask1_n[l];
    assign lane_touch[l] = !mask0_n[l] || !mask1_n[l];
    assign new_word[l]   = full ? encode(mrg) : put_data(old_w, mrg);

    assign rd_w   = mem[rd_addr][l];
    assign s      = syndrome(rd_w);
    assign lane_hit[l] = !ecc_off && (s != 5'd0) && (s <= 5'd23);
    assign fixed_w = lane_hit[l] ? (rd_w ^ (CW'(1) << (s - 5'd1))) : rd_w;
    assign rd_dat[l] = get_data(fixed_w);
  end

  assign inj_mask = (inj_pos >= 5'd1 && inj_pos <= 5'd23) ? (CW'(1) << (inj_pos - 5'd1)) : '0;
  assign inj_base = (wr_en && wr_addr == inj_addr && lane_touch[inj_lane])
                    ? new_word[inj_lane] : mem[inj_addr][inj_lane];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (wr_en && lane_touch[l]) mem[wr_addr][l] <= new_word[l];
    if (inj_en) mem[inj_addr][inj_lane] <= inj_base ^ inj_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) ecc_off <= 1'b0;
    else if (wr_en && |(mask0_n ^ mask1_n)) ecc_off <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_fix   <= 1'b0;
      rd_q0    <= '0;
      rd_q1    <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_fix   <= rd_en && |lane_hit;
      if (rd_en)
        for (int l = 0; l < LANES; l++) begin
          rd_q0[9*l +: 9] <= rd_dat[l][8:0];
          rd_q1[9*l +: 9] <= rd_dat[l][17:9];
        end
    end
  end
endmodule

// File: rtl/ecc_word_store_chk.sv
module ecc_word_store_chk #(
  parameter int LANES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [LANES-1:0]   mask0_n,
  input logic [LANES-1:0]   mask1_n,
  input logic               rd_en,
  input logic [9*LANES-1:0] rd_q0,
  input logic [9*LANES-1:0] rd_q1,
  input logic               rd_valid,
  input logic               rd_fix,
  input logic               ecc_off
);
  a_r6_off_sticky: assert property (@(posedge clk) disable iff (rst)
    ecc_off |=> ecc_off);

  a_r6_half_sets_off: assert property (@(posedge clk) disable iff (rst)
    (wr_en && |(mask0_n ^ mask1_n)) |=> ecc_off);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && !rd_fix && $stable(rd_q0) && $stable(rd_q1)));

  a_r7_no_fix_when_off: assert property (@(posedge clk) disable iff (rst)
    rd_fix |-> ($past(!ecc_off) && rd_valid));
endmodule

bind ecc_word_store ecc_word_store_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .mask0_n(mask0_n), .mask1_n(mask1_n),
  .rd_en(rd_en), .rd_q0(rd_q0), .rd_q1(rd_q1), .rd_valid(rd_valid),
  .rd_fix(rd_fix), .ecc_off(ecc_off)
);

// File: tb/ecc_word_store_bench.sv
`timescale 1ns/1ps
module ecc_word_store_bench;
  localparam int LANES = 2;
  localparam int AW = 3;
  localparam int W = 9 * LANES;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, inj_en = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0, inj_addr = 0;
  logic [W-1:0] wr_d0 = 0, wr_d1 = 0;
  logic [LANES-1:0] mask0_n = '1, mask1_n = '1;
  logic [0:0] inj_lane = 0;
  logic [4:0] inj_pos = 0;
  logic [W-1:0] rd_q0, rd_q1;
  logic rd_valid, rd_fix, ecc_off;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [W-1:0] m0 [DEPTH];
  logic [W-1:0] m1 [DEPTH];

  always #2.5 clk = ~clk;

  ecc_word_store #(.LANES(LANES), .AW(AW)) u_ecc_word_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_d0(wr_d0), .wr_d1(wr_d1),
    .mask0_n(mask0_n), .mask1_n(mask1_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_lane(inj_lane), .inj_pos(inj_pos),
    .rd_q0(rd_q0), .rd_q1(rd_q1), .rd_valid(rd_valid), .rd_fix(rd_fix), .ecc_off(ecc_off));

  function automatic logic [W-1:0] pat(input int a, input int s);
    return W'((a * 691 + s * 4951 + 17) ^ 'h2A5A5);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                    input logic [LANES-1:0] k0, input logic [LANES-1:0] k1);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_d0 = d0; wr_d1 = d1; mask0_n = k0; mask1_n = k1;
    for (int l = 0; l < LANES; l++) begin
      if (!k0[l]) m0[a][9*l +: 9] = d0[9*l +: 9];
      if (!k1[l]) m1[a][9*l +: 9] = d1[9*l +: 9];
    end
    @(negedge clk);
    wr_en = 0; mask0_n = '1; mask1_n = '1;
  endtask

  task automatic rd(input int a, input logic [W-1:0] e0, input logic [W-1:0] e1,
                    input bit efix, input string tag);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid === 1'b1, {tag, " valid"}, W'(rd_valid), W'(1));
    chk(rd_q0 === e0, {tag, " beat1"}, rd_q0, e0);
    chk(rd_q1 === e1, {tag, " beat2"}, rd_q1, e1);
    chk(rd_fix === efix, {tag, " fix"}, W'(rd_fix), W'(efix));
  endtask

  task automatic inj(input int a, input int lane, input int pos);
    @(negedge clk);
    inj_en = 1; inj_addr = AW'(a); inj_lane = 1'(lane); inj_pos = 5'(pos);
    @(negedge clk);
    inj_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rd_valid === 0 && rd_fix === 0 && ecc_off === 0, "R1 reset state",
        W'({rd_valid, rd_fix, ecc_off}), '0);

    // R2 full writes, two pattern sets
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < DEPTH; a++) wr(a, pat(a, s), pat(a, s + 7), '0, '0);
      for (int a = 0; a < DEPTH; a++) rd(a, m0[a], m1[a], 0, "R2 full write readback");
    end
    wr(0, '1, '0, '0, '0);
    rd(0, m0[0], m1[0], 0, "R2 ones/zeros");

    // R11 idle holds
    @(negedge clk);
    chk(rd_valid === 0 && rd_fix === 0 && rd_q0 === m0[0] && rd_q1 === m1[0],
        "R11 idle hold", rd_q0, m0[0]);

    // R3 / R4 / R12 every code-word position on every lane
    for (int l = 0; l < LANES; l++)
      for (int p = 1; p <= 23; p++) begin
        inj(3, l, p);
        rd(3, m0[3], m1[3], 1, (p & (p - 1)) == 0 ? "R4 check-bit hit" : "R3 data-bit hit");
        inj(3, l, p);
      end
    rd(3, m0[3], m1[3], 0, "R12 restored word clean");
    inj(3, 0, 0);
    inj(3, 1, 30);
    rd(3, m0[3], m1[3], 0, "R12 out-of-range position no effect");

    // R8 full rewrite regenerates check bits
    inj(5, 1, 7);
    wr(5, pat(5, 11), pat(5, 12), '0, '0);
    rd(5, m0[5], m1[5], 0, "R8 rewrite clears error");

    // R5 / R10 per-lane full and abort
    wr(2, pat(2, 20), pat(2, 21), 2'b10, 2'b10);
    rd(2, m0[2], m1[2], 0, "R10 lane0 full lane1 abort");
    wr(2, pat(2, 22), pat(2, 23), 2'b01, 2'b01);
    rd(2, m0[2], m1[2], 0, "R10 lane1 full lane0 abort");
    wr(2, pat(2, 24), pat(2, 25), 2'b11, 2'b11);
    rd(2, m0[2], m1[2], 0, "R5 both lanes abort");
    chk(ecc_off === 0, "R5 no half write keeps ecc on", W'(ecc_off), '0);

    // R9 read during write
    begin
      logic [W-1:0] o0, o1;
      o0 = m0[4]; o1 = m1[4];
      @(negedge clk);
      wr_en = 1; wr_addr = 4; wr_d0 = pat(4, 30); wr_d1 = pat(4, 31);
      mask0_n = '0; mask1_n = '0; rd_en = 1; rd_addr = 4;
      m0[4] = pat(4, 30); m1[4] = pat(4, 31);
      @(negedge clk);
      wr_en = 0; rd_en = 0; mask0_n = '1; mask1_n = '1;
      chk(rd_q0 === o0 && rd_q1 === o1, "R9 read sees old data", rd_q0, o0);
      rd(4, m0[4], m1[4], 0, "R9 new data after write");
    end

    // R6 half writes
    wr(1, pat(1, 40), pat(1, 41), 2'b10, 2'b11);
    chk(ecc_off === 1, "R6 half write sets ecc_off", W'(ecc_off), W'(1));
    rd(1, m0[1], m1[1], 0, "R6 beat1-only lane0 merge");
    wr(1, pat(1, 42), pat(1, 43), 2'b11, 2'b01);
    rd(1, m0[1], m1[1], 0, "R6 beat2-only lane1 merge");

    // R7 raw data when off
    inj(6, 0, 3);
    rd(6, m0[6] ^ W'(1), m1[6], 0, "R7 data error returned raw");
    inj(6, 0, 3);
    inj(7, 1, 1);
    rd(7, m0[7], m1[7], 0, "R7 check error no fix");

    // R6 sticky, R1 reset clears
    for (int a = 0; a < 4; a++) wr(a, pat(a, 50), pat(a, 51), '0, '0);
    chk(ecc_off === 1, "R6 ecc_off sticky", W'(ecc_off), W'(1));
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(ecc_off === 0 && rd_valid === 0, "R1 reset clears ecc_off", W'(ecc_off), '0);
    rd(0, m0[0], m1[0], 0, "R2 data after reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule